// File: doc/BRIEF.md
# Word-to-Byte Bus Cycle Sequencer with Halt Stepping and Rerun

This block is a bus master sequencer. It takes one 32-bit word access at a time from an internal requester and runs it on an external bus with separate address and data strobes. The port size is learned per cycle from a two-bit acknowledge code. A 32-bit acknowledge finishes the word in one cycle. An 8-bit acknowledge makes the sequencer split the word into byte cycles at rising addresses. The byte at the lowest address is the most significant one, and it always travels on the top lane.

Two debug and recovery inputs shape the flow. A halt request freezes the sequencer at the next cycle boundary and never cuts a running cycle short. Lowering halt for a single clock while the sequencer is frozen lets exactly one bus cycle through, so an external debugger can step the bus cycle by cycle. A bus error that arrives together with halt is not reported: the cycle ends, and once halt drops the whole word access starts again from its first byte, even when earlier bytes had already been accepted. A bus error without halt ends the access with an error response.

Top module: `bus_seq_ctl`

## Requirements
- R1: During and directly after reset, `bus_as`, `bus_ds` and `rsp_valid` are low.
- R2: `bus_ack` is coded 00 = no acknowledge, 01 = 8-bit port, 10 or 11 = 32-bit port. A 32-bit acknowledge completes the whole word access in one bus cycle.
- R3: On an 8-bit port a word takes four cycles at addresses base, base+1, base+2, base+3. In cycle k, `bus_wdata` is the write word shifted left by 8k bits, so byte k sits on bits 31:24. A read places the bits 31:24 of cycle k into bits (31-8k):(24-8k) of `rsp_rdata`. The byte at the lowest address is bits 31:24 of the word.
- R4: Each bus cycle holds `bus_as` and `bus_ds` high for one address clock and then through the data phase until an acknowledge or a bus error is sampled. Both are then low for at least one termination clock. The address does not change while the strobes stay high.
- R5: While `bus_halt` is high at a cycle boundary (idle with a pending request, or between the cycles of one access), no new bus cycle starts.
- R6: Raising `bus_halt` during a cycle does not end that cycle. It runs until its acknowledge.
- R7: With the sequencer held at a boundary, lowering `bus_halt` for exactly one clock lets exactly one bus cycle run.
- R8: `bus_berr` and `bus_halt` sampled high together end the cycle without an error response. After halt drops, the access reruns from byte 0 with the same address, direction and write data.
- R9: `bus_berr` sampled with `bus_halt` low ends the access with `rsp_valid` and `rsp_err` both high, and no further cycle of that access follows.
- R10: `rsp_valid` is a one-clock pulse in the termination clock of the access's last cycle. On a read, `rsp_rdata` holds the assembled word in that clock.
- R11: `bus_rw` is high for a read access and low for a write access, and it stays stable while the strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Requester holds this high until the response pulse |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | AW | Word access base address |
| req_wdata | input | DW | Write word |
| rsp_valid | output | 1 | Access finished (one clock) |
| rsp_err | output | 1 | Access ended in a bus error |
| rsp_rdata | output | DW | Assembled read word |
| bus_addr | output | AW | External address |
| bus_as | output | 1 | Address strobe, active high |
| bus_ds | output | 1 | Data strobe, active high |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_wdata | output | DW | Write data, current byte on the top lane |
| bus_rdata | input | DW | Read data from the external bus |
| bus_ack | input | 2 | Port-size acknowledge code |
| bus_berr | input | 1 | Bus error |
| bus_halt | input | 1 | Halt request |

## Verification
The assertions assume that `bus_ack`, `bus_berr` and `bus_halt` are synchronous to `clk`. They also assume that the external port raises an acknowledge or a bus error only while `bus_as` is high, drops it once the strobes are low, and never raises both in the same cycle. The requester is assumed to hold its request fields stable until the response. The bench's slave model keeps to these rules. It drives its inputs on the falling edge, replies only to an active strobe, injects at most one bus error per chosen cycle, and releases its own halt a fixed number of clocks after a rerun request. The randomised accesses vary only the port size, the wait states, the address and the data.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_TERM,
    ST_HOLD
  } seq_state_e;

  typedef enum logic [1:0] {
    END_MORE,
    END_DONE,
    END_RETRY,
    END_FAULT
  } cyc_end_e;

  localparam logic [1:0] ACK_NONE = 2'b00;
  localparam logic [1:0] ACK_BYTE = 2'b01;

endpackage

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
  import bus_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] bus_ack,
  input  logic       bus_berr,
  input  logic       bus_halt,
  input  logic       last_byte,
  output logic       take_req,
  output logic       restart_word,
  output logic       step_byte,
  output logic       cap_byte,
  output logic       cap_word,
  output logic       strobe,
  output logic       rsp_valid,
  output logic       rsp_err
);

  seq_state_e state_q, state_d;
  cyc_end_e   end_q, end_d;
  logic       end_en;

  always_comb begin
    state_d      = state_q;
    end_d        = end_q;
    end_en       = 1'b0;
    take_req     = 1'b0;
    restart_word = 1'b0;
    step_byte    = 1'b0;
    cap_byte     = 1'b0;
    cap_word     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid && !bus_halt) begin
          take_req = 1'b1;
          state_d  = ST_ADDR;
        end
      end
      ST_ADDR: state_d = ST_DATA;
      ST_DATA: begin
        if (bus_berr) begin
          end_en  = 1'b1;
          end_d   = bus_halt ? END_RETRY : END_FAULT;
          state_d = ST_TERM;
        end else if (bus_ack == ACK_BYTE) begin
          cap_byte = 1'b1;
          end_en   = 1'b1;
          end_d    = last_byte ? END_DONE : END_MORE;
          state_d  = ST_TERM;
        end else if (bus_ack[1]) begin
          cap_word = 1'b1;
          end_en   = 1'b1;
          end_d    = END_DONE;
          state_d  = ST_TERM;
        end
      end
      ST_TERM: begin
        unique case (end_q)
          END_MORE: begin
            step_byte = 1'b1;
            state_d   = bus_halt ? ST_HOLD : ST_ADDR;
          end
          END_RETRY: begin
            restart_word = 1'b1;
            state_d      = bus_halt ? ST_HOLD : ST_ADDR;
          end
          default: state_d = ST_IDLE;
        endcase
      end
      ST_HOLD: begin
        if (!bus_halt) state_d = ST_ADDR;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_q <= END_DONE;
    end else if (end_en) begin
      end_q <= end_d;
    end
  end

  assign strobe    = (state_q == ST_ADDR) || (state_q == ST_DATA);
  assign rsp_valid = (state_q == ST_TERM) && ((end_q == END_DONE) || (end_q == END_FAULT));
  assign rsp_err   = (state_q == ST_TERM) && (end_q == END_FAULT);

  a_r5_no_start_halted: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |-> !$past(bus_halt));

  a_r6_no_cut_short: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && (bus_ack == ACK_NONE) && !bus_berr) |=> strobe);

  a_r4_term_release: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_DATA) && ((bus_ack != ACK_NONE) || bus_berr)) |=> !strobe);

  a_r10_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r9_no_cycle_after_resp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !strobe);

  a_r1_quiet_reset: assert property (@(posedge clk)
    !rst_n |-> (!strobe && !rsp_valid));

endmodule

// File: rtl/bus_seq_lanes.sv
module bus_seq_lanes #(
  parameter int AW = 24,
  parameter int DW = 32,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_req,
  input  logic          restart_word,
  input  logic          step_byte,
  input  logic          cap_byte,
  input  logic          cap_word,
  input  logic          strobe,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_rw,
  output logic          last_byte,
  output logic [DW-1:0] rsp_rdata
);

  localparam int NB = DW / LW;
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;

  logic [AW-1:0] base_q;
  logic [DW-1:0] wdat_q;
  logic          wr_q;
  logic [IW-1:0] idx_q, idx_d;
  logic          idx_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      wdat_q <= '0;
      wr_q   <= 1'b0;
    end else if (take_req) begin
      base_q <= req_addr;
      wdat_q <= req_wdata;
      wr_q   <= req_write;
    end
  end

  always_comb begin
    idx_en = take_req || restart_word || step_byte;
    idx_d  = step_byte ? (idx_q + 1'b1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  assign bus_addr  = base_q + AW'(idx_q);
  assign bus_wdata = wdat_q << (idx_q * LW);
  assign bus_rw    = !wr_q;
  assign last_byte = (idx_q == IW'(NB - 1));

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [LW-1:0] lane_q;
    logic          lane_hit;
    assign lane_hit = cap_byte && (idx_q == IW'(NB - 1 - g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q <= '0;
      end else if (cap_word) begin
        lane_q <= bus_rdata[g*LW +: LW];
      end else if (lane_hit) begin
        lane_q <= bus_rdata[DW-1 -: LW];
      end
    end
    assign rsp_rdata[g*LW +: LW] = lane_q;
  end

  a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (!strobe || $stable(bus_addr)));

  a_r11_rw_stable: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (!strobe || $stable(bus_rw)));

  a_r3_lane_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    step_byte |-> !last_byte);

endmodule

// File: rtl/bus_seq_ctl.sv
module bus_seq_ctl #(
  parameter int AW = 24,
  parameter int DW = 32,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] bus_addr,
  output logic          bus_as,
  output logic          bus_ds,
  output logic          bus_rw,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic [1:0]    bus_ack,
  input  logic          bus_berr,
  input  logic          bus_halt
);

  logic take_req, restart_word, step_byte, cap_byte, cap_word;
  logic strobe, last_byte;

  bus_seq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .bus_ack      (bus_ack),
    .bus_berr     (bus_berr),
    .bus_halt     (bus_halt),
    .last_byte    (last_byte),
    .take_req     (take_req),
    .restart_word (restart_word),
    .step_byte    (step_byte),
    .cap_byte     (cap_byte),
    .cap_word     (cap_word),
    .strobe       (strobe),
    .rsp_valid    (rsp_valid),
    .rsp_err      (rsp_err)
  );

  bus_seq_lanes #(.AW(AW), .DW(DW), .LW(LW)) u_lanes (
    .clk          (clk),
    .rst_n        (rst_n),
    .take_req     (take_req),
    .restart_word (restart_word),
    .step_byte    (step_byte),
    .cap_byte     (cap_byte),
    .cap_word     (cap_word),
    .strobe       (strobe),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .bus_rdata    (bus_rdata),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rw       (bus_rw),
    .last_byte    (last_byte),
    .rsp_rdata    (rsp_rdata)
  );

  assign bus_as = strobe;
  assign bus_ds = strobe;

endmodule

// File: tb/bus_seq_ctl_test.sv
module bus_seq_ctl_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid, rsp_err;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] bus_addr;
  logic          bus_as, bus_ds, bus_rw;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] s_rdata = '0;
  logic [1:0]    s_ack = 2'b00;
  logic          s_berr = 1'b0;
  logic          s_halt = 1'b0;
  logic          tb_halt = 1'b0;
  logic          bus_halt;

  assign bus_halt = tb_halt | s_halt;

  bus_seq_ctl #(.AW(AW), .DW(DW), .LW(8)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .bus_addr(bus_addr), .bus_as(bus_as), .bus_ds(bus_ds), .bus_rw(bus_rw),
    .bus_wdata(bus_wdata), .bus_rdata(s_rdata), .bus_ack(s_ack),
    .bus_berr(s_berr), .bus_halt(bus_halt)
  );

  // slave model settings
  logic [7:0] mem [0:255];
  bit         byte_port = 1'b0;
  logic [1:0] s_wcode = 2'b10;
  int         s_wait = 0;
  int         inj_at = 0;
  bit         inj_halt = 1'b0;
  int         n_cyc = 0;
  int         wcnt = 0;
  int         halt_cnt = 0;
  logic       as_prev = 1'b0;
  logic [7:0] log_addr [0:15];
  logic [7:0] log_top  [0:15];
  logic       log_rw   [0:15];

  int n_tests = 0;
  int n_fail = 0;
  logic          r_err;
  logic [DW-1:0] r_data;
  int            r_cyc;

  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_as && !as_prev) begin
        n_cyc = n_cyc + 1;
        log_addr[n_cyc % 16] = bus_addr[7:0];
        log_top[n_cyc % 16]  = bus_wdata[31:24];
        log_rw[n_cyc % 16]   = bus_rw;
        wcnt = 0;
      end
      if (!bus_as) begin
        s_ack  = 2'b00;
        s_berr = 1'b0;
      end else if (s_ack == 2'b00 && !s_berr) begin
        if (wcnt < s_wait) begin
          wcnt = wcnt + 1;
        end else if (n_cyc == inj_at) begin
          inj_at = 0;
          s_berr = 1'b1;
          if (inj_halt) begin
            s_halt   = 1'b1;
            halt_cnt = 5;
          end
        end else if (byte_port) begin
          s_ack = 2'b01;
          if (!bus_rw) mem[bus_addr[7:0]] = bus_wdata[31:24];
          else s_rdata = {mem[bus_addr[7:0]], 24'h0};
        end else begin
          s_ack = s_wcode;
          for (int k = 0; k < 4; k++) begin
            if (!bus_rw) mem[8'(bus_addr[7:0] + 8'(k))] = bus_wdata[31-8*k -: 8];
            else s_rdata[31-8*k -: 8] = mem[8'(bus_addr[7:0] + 8'(k))];
          end
        end
      end
      if (halt_cnt > 0) begin
        halt_cnt = halt_cnt - 1;
        if (halt_cnt == 0) s_halt = 1'b0;
      end
      as_prev = bus_as;
    end
  end

  function automatic logic [31:0] exp_word(input logic [7:0] a);
    return {mem[a], mem[8'(a + 8'd1)], mem[8'(a + 8'd2)], mem[8'(a + 8'd3)]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_access(input bit wr, input logic [7:0] a, input logic [31:0] d);
    int c0;
    int to;
    c0 = n_cyc;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d;
    to = 0;
    do begin
      @(negedge clk);
      to++;
    end while (!rsp_valid && to < 3000);
    r_err = rsp_err; r_data = rsp_rdata; r_cyc = n_cyc - c0;
    req_valid = 1'b0;
    chk(to < 3000, "R10 response arrives", 32'(to), 32'd0);
    @(negedge clk);
    chk(!rsp_valid, "R10 response is one clock", 32'(rsp_valid), 32'd0);
  endtask

  task automatic report;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    for (int i = 0; i < 16; i++) begin
      log_addr[i] = '0; log_top[i] = '0; log_rw[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    chk(!bus_as && !bus_ds && !rsp_valid, "R1 outputs quiet in reset", {bus_as, bus_ds, rsp_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_as && !bus_ds && !rsp_valid, "R1 outputs quiet after reset", {bus_as, bus_ds, rsp_valid}, 0);

    // random traffic: R2, R3, R11
    for (int i = 0; i < 30; i++) begin
      logic [7:0]  a;
      logic [31:0] d;
      bit          bp;
      a = 8'($urandom % 256);
      d = $urandom;
      bp = 1'($urandom % 2);
      byte_port = bp; s_wait = int'($urandom % 3);
      run_access(1'b1, a, d);
      chk(!r_err, "R9 no error on clean write", 32'(r_err), 0);
      chk(r_cyc == (bp ? 4 : 1), bp ? "R3 byte write cycles" : "R2 word write cycles", 32'(r_cyc), bp ? 4 : 1);
      chk(exp_word(a) == d, "R3 stored byte order", exp_word(a), d);
      chk(log_rw[n_cyc % 16] == 1'b0, "R11 write direction", 32'(log_rw[n_cyc % 16]), 0);
      bp = 1'($urandom % 2);
      byte_port = bp; s_wait = int'($urandom % 3);
      run_access(1'b0, a, 32'h0);
      chk(r_data == d, "R10 read data assembled", r_data, d);
      chk(r_cyc == (bp ? 4 : 1), bp ? "R3 byte read cycles" : "R2 word read cycles", 32'(r_cyc), bp ? 4 : 1);
      chk(log_rw[n_cyc % 16] == 1'b1, "R11 read direction", 32'(log_rw[n_cyc % 16]), 1);
    end
    s_wait = 0;

    // R3 addresses and lanes of a split write
    begin
      int c0;
      byte_port = 1'b1; c0 = n_cyc;
      run_access(1'b1, 8'h40, 32'hA1B2C3D4);
      for (int k = 0; k < 4; k++) begin
        chk(log_addr[(c0 + 1 + k) % 16] == 8'(8'h40 + 8'(k)), "R3 byte address", 32'(log_addr[(c0 + 1 + k) % 16]), 32'(8'h40 + k));
      end
      chk(log_top[(c0 + 2) % 16] == 8'hB2, "R3 second byte on top lane", 32'(log_top[(c0 + 2) % 16]), 32'hB2);
    end

    // R2 code 11 counts as a 32-bit acknowledge
    byte_port = 1'b0; s_wcode = 2'b11;
    run_access(1'b0, 8'h40, 32'h0);
    chk(r_cyc == 1 && r_data == 32'hA1B2C3D4, "R2 code 11 is 32-bit", r_data, 32'hA1B2C3D4);
    s_wcode = 2'b10;

    // R5 halt at idle boundary holds a pending request
    begin
      int c0;
      c0 = n_cyc; tb_halt = 1'b1;
      fork
        run_access(1'b0, 8'h40, 32'h0);
        begin
          repeat (30) @(negedge clk);
          chk(n_cyc == c0, "R5 no cycle while halted", 32'(n_cyc - c0), 0);
          chk(!rsp_valid, "R5 no response while halted", 32'(rsp_valid), 0);
          tb_halt = 1'b0;
        end
      join
      chk(r_cyc == 1 && r_data == 32'hA1B2C3D4, "R5 access runs after release", r_data, 32'hA1B2C3D4);
    end

    // R6 halt mid-cycle, R7 single stepping
    begin
      int c0;
      c0 = n_cyc; byte_port = 1'b1; s_wait = 3;
      fork
        run_access(1'b0, 8'h40, 32'h0);
        begin
          while (n_cyc != c0 + 1) @(negedge clk);
          tb_halt = 1'b1;
          repeat (20) @(negedge clk);
          chk(n_cyc == c0 + 1, "R5 halted between bytes", 32'(n_cyc - c0), 1);
          chk(!bus_as, "R6 running cycle completed", 32'(bus_as), 0);
          for (int s = 1; s <= 3; s++) begin
            @(negedge clk); tb_halt = 1'b0;
            @(negedge clk); tb_halt = 1'b1;
            repeat (15) @(negedge clk);
            chk(n_cyc == c0 + 1 + s, "R7 one cycle per step", 32'(n_cyc - c0), 32'(1 + s));
          end
        end
      join
      tb_halt = 1'b0; s_wait = 0;
      chk(r_data == 32'hA1B2C3D4 && r_cyc == 4, "R7 stepped read data", r_data, 32'hA1B2C3D4);
    end

    // R8 rerun after berr+halt on the second byte
    begin
      int c0;
      c0 = n_cyc; byte_port = 1'b1; inj_halt = 1'b1; inj_at = n_cyc + 2;
      run_access(1'b1, 8'h60, 32'h5A6B7C8D);
      chk(!r_err, "R8 no error on rerun", 32'(r_err), 0);
      chk(r_cyc == 6, "R8 whole word reruns", 32'(r_cyc), 6);
      chk(log_addr[(c0 + 3) % 16] == 8'h60, "R8 rerun restarts at base", 32'(log_addr[(c0 + 3) % 16]), 32'h60);
      chk(log_top[(c0 + 3) % 16] == 8'h5A, "R8 rerun same first byte", 32'(log_top[(c0 + 3) % 16]), 32'h5A);
      chk(exp_word(8'h60) == 32'h5A6B7C8D, "R8 word stored after rerun", exp_word(8'h60), 32'h5A6B7C8D);
      byte_port = 1'b0; inj_at = n_cyc + 1;
      run_access(1'b0, 8'h60, 32'h0);
      chk(!r_err && r_cyc == 2 && r_data == 32'h5A6B7C8D, "R8 word port rerun", r_data, 32'h5A6B7C8D);
    end

    // R9 plain bus error
    begin
      int c1;
      byte_port = 1'b1; inj_halt = 1'b0; inj_at = n_cyc + 2;
      run_access(1'b0, 8'h80, 32'h0);
      chk(r_err == 1'b1, "R9 error response", 32'(r_err), 1);
      chk(r_cyc == 2, "R9 stops at failing byte", 32'(r_cyc), 2);
      c1 = n_cyc;
      repeat (10) @(negedge clk);
      chk(n_cyc == c1, "R9 no cycle after error", 32'(n_cyc - c1), 0);
    end

    report();
  end

endmodule